// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block keeps one address reservation for a single processor and serves the two halves of an atomic read-modify-write sequence. A locked load forms its effective address from a base register plus a sign-extended 12-bit displacement. It issues a read strobe and records that address as the reservation. A later conditional store forms its own address the same way. It issues a memory write only when the reservation is still held and covers the store's address. It also returns a value of 1 or 0 that replaces the store's data register.

Both operations exist in a 32-bit form and a 64-bit form, selected by a function code. Any conditional store consumes the reservation, whether it succeeds or fails. The clear input lets the surrounding system drop the reservation when another agent writes the reserved location. Memory and address translation sit outside; the block only drives strobes, address, size and write data.

Top module: `llsc_monitor`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it, every strobe is 0. No reservation is held after reset, so a conditional store with no prior locked load fails.
- R2: The effective address is `base_i` plus `disp_i` sign-extended from 12 bits, modulo 2^AW. It appears on `mem_addr_o` with `mem_rd_o` = 1 one cycle after a locked load.
- R3: Function code 2 selects the 32-bit form and code 3 the 64-bit form; `mem_quad_o` is 1 for the 64-bit form. A request with any other code produces no strobe and leaves the reservation unchanged.
- R4: A locked load records its address. A following conditional store whose address matches succeeds: one cycle later `mem_we_o` = 1, `mem_wdata_o` = `data_i`, `sc_done_o` = 1 and `sc_result_o` = 1.
- R5: A conditional store without a matching reservation fails: `sc_done_o` = 1, `sc_result_o` = 0 and `mem_we_o` = 0.
- R6: Every accepted conditional store drops the reservation, so a second store to the same address fails.
- R7: `clr_i` drops the reservation. A store in the same cycle as `clr_i` fails. A locked load in the same cycle as `clr_i` still sets its reservation.
- R8: For the 64-bit form, only address bits 3 and above are compared. For the 32-bit form, bits 2 and above are compared.
- R9: A new locked load replaces the reserved address, so a store to the old address fails.
- R10: `op_i` = 0 (idle) and `op_i` = 3 (reserved) produce no strobe and leave the reservation unchanged. `op_i` = 1 is the locked load and `op_i` = 2 is the conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | 0 idle, 1 locked load, 2 conditional store, 3 reserved |
| func_i | input | 4 | Function code: 2 = 32-bit, 3 = 64-bit |
| base_i | input | AW | Base register value |
| disp_i | input | 12 | Signed displacement |
| data_i | input | DW | Store source register value |
| clr_i | input | 1 | Conflicting write by another agent |
| mem_rd_o | output | 1 | Locked load read strobe |
| mem_we_o | output | 1 | Conditional store write strobe |
| mem_quad_o | output | 1 | Access is 64-bit |
| mem_addr_o | output | AW | Effective address |
| mem_wdata_o | output | DW | Write data |
| sc_done_o | output | 1 | Conditional store completed |
| sc_result_o | output | DW | Value replacing the store data register (1 or 0) |

## Verification
Every result leaves the block one rising edge after the request is sampled: the strobes, address, write data and success value are all registered once. The reservation updates on that same edge, so its effect is seen on the next request's result. The bench drives each request on a falling edge and samples the outputs on the following falling edge, with nothing in between. Clear, reset and replacement cases are placed at the request just before the store they are meant to affect.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LDL  = 2'd1,
    OP_STC  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  localparam int unsigned DISP_W  = 12;
  localparam logic [3:0]  FN_LONG = 4'd2;
  localparam logic [3:0]  FN_QUAD = 4'd3;
endpackage

// File: rtl/llsc_agen.sv
module llsc_agen #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DISP_W = 12
) (
  input  logic [AW-1:0]     base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [AW-1:0]     ea_o
);
  localparam int unsigned EXT_W = AW - DISP_W;

  logic [AW-1:0] disp_sx;
  assign disp_sx = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign ea_o    = base_i + disp_sx;
endmodule

// File: rtl/llsc_rsv.sv
module llsc_rsv #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          chk_i,
  input  logic          clr_i,
  input  logic          quad_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] cmp_mask;

  // granule: 8 bytes for the 64-bit form, 4 bytes for the 32-bit form
  assign cmp_mask = {{(AW-3){1'b1}}, ~quad_i, 2'b00};
  assign hit_o    = valid_q && !clr_i && (((addr_q ^ addr_i) & cmp_mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
    end else if (chk_i || clr_i) begin
      valid_q <= 1'b0;
    end
  end

  // R4
  rsv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> valid_q);
  // R6
  rsv_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_i |=> !valid_q);
  // R7
  rsv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !valid_q);
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_go_i,
  input  logic          st_go_i,
  input  logic          hit_i,
  input  logic          quad_i,
  input  logic [AW-1:0] ea_i,
  input  logic [DW-1:0] data_i,
  output logic          mem_rd_o,
  output logic          mem_we_o,
  output logic          mem_quad_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          sc_done_o,
  output logic [DW-1:0] sc_result_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rd_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_quad_o  <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      sc_done_o   <= 1'b0;
      ok_q        <= 1'b0;
    end else begin
      mem_rd_o  <= ld_go_i;
      mem_we_o  <= st_go_i && hit_i;
      sc_done_o <= st_go_i;
      ok_q      <= st_go_i && hit_i;
      if (ld_go_i || st_go_i) begin
        mem_addr_o <= ea_i;
        mem_quad_o <= quad_i;
      end
      if (st_go_i) mem_wdata_o <= data_i;
    end
  end

  assign sc_result_o = {{(DW-1){1'b0}}, ok_q};

  // R4
  we_implies_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (sc_done_o && sc_result_o == DW'(1)));
  // R5
  fail_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_done_o && sc_result_o == '0) |-> !mem_we_o);
  // R10
  one_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && sc_done_o));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic [3:0]        func_i,
  input  logic [AW-1:0]     base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DW-1:0]     data_i,
  input  logic              clr_i,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic              mem_quad_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              sc_done_o,
  output logic [DW-1:0]     sc_result_o
);
  logic          fn_ok, quad, ld_go, st_go, hit;
  logic [AW-1:0] ea;

  assign fn_ok = (func_i == FN_LONG) || (func_i == FN_QUAD);
  assign quad  = (func_i == FN_QUAD);
  assign ld_go = fn_ok && (op_e'(op_i) == OP_LDL);
  assign st_go = fn_ok && (op_e'(op_i) == OP_STC);

  llsc_agen #(.AW(AW), .DISP_W(DISP_W)) u_agen (
    .base_i (base_i),
    .disp_i (disp_i),
    .ea_o   (ea)
  );

  llsc_rsv #(.AW(AW)) u_rsv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ld_go),
    .chk_i  (st_go),
    .clr_i  (clr_i),
    .quad_i (quad),
    .addr_i (ea),
    .hit_o  (hit)
  );

  llsc_resp #(.AW(AW), .DW(DW)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_go_i     (ld_go),
    .st_go_i     (st_go),
    .hit_i       (hit),
    .quad_i      (quad),
    .ea_i        (ea),
    .data_i      (data_i),
    .mem_rd_o    (mem_rd_o),
    .mem_we_o    (mem_we_o),
    .mem_quad_o  (mem_quad_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .sc_done_o   (sc_done_o),
    .sc_result_o (sc_result_o)
  );

  // R3
  bad_fn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fn_ok |=> (!mem_rd_o && !sc_done_o && !mem_we_o));
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int AW = 32;
  localparam int DW = 64;

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;
    logic [3:0]  fn;
    logic [31:0] base;
    logic [11:0] disp;
    logic [63:0] data;
    logic        clr;
    logic        rd;
    logic        we;
    logic        done;
    logic        res;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 31;
  // fields: req, op, fn, base, disp, data, clr, rd, we, done, res, addr
  localparam vec_t VECS [NV] = '{
    '{8'd5,  2'd2, 4'd3, 32'h0000_0100, 12'h000, 64'hAA,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0100}, // R5
    '{8'd2,  2'd1, 4'd3, 32'h0000_1000, 12'h010, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1010}, // R2
    '{8'd8,  2'd2, 4'd3, 32'h0000_1000, 12'h014, 64'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_1014}, // R8 bit2 ignored
    '{8'd6,  2'd2, 4'd3, 32'h0000_1000, 12'h010, 64'h55,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_1010}, // R6
    '{8'd2,  2'd1, 4'd2, 32'h0000_2000, 12'hFFC, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1FFC}, // R2 negative
    '{8'd8,  2'd2, 4'd2, 32'h0000_1FF0, 12'h00E, 64'h77,   1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_1FFE}, // R8 bit1 ignored
    '{8'd4,  2'd1, 4'd2, 32'h0000_3000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_3000}, // R4
    '{8'd8,  2'd2, 4'd2, 32'h0000_3004, 12'h000, 64'h1,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_3004}, // R8 bit2 compared
    '{8'd4,  2'd1, 4'd3, 32'h0000_4000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_4000}, // R4
    '{8'd8,  2'd2, 4'd3, 32'h0000_4008, 12'h000, 64'h1,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_4008}, // R8 bit3 compared
    '{8'd4,  2'd1, 4'd3, 32'h0000_5000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_5000}, // R4
    '{8'd3,  2'd1, 4'd1, 32'h0000_6000, 12'h000, 64'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R3 bad code
    '{8'd10, 2'd3, 4'd3, 32'h0000_6000, 12'h000, 64'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R10 reserved op
    '{8'd10, 2'd0, 4'd3, 32'h0000_6000, 12'h000, 64'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R10 idle
    '{8'd3,  2'd2, 4'd0, 32'h0000_5000, 12'h000, 64'h9,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R3 bad code store
    '{8'd3,  2'd2, 4'd3, 32'h0000_5000, 12'h000, 64'hBEEF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_5000}, // R3 reservation kept
    '{8'd4,  2'd1, 4'd3, 32'h0000_7000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_7000},
    '{8'd7,  2'd0, 4'd0, 32'h0,         12'h000, 64'h0,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R7 clear
    '{8'd7,  2'd2, 4'd3, 32'h0000_7000, 12'h000, 64'h3,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_7000}, // R7
    '{8'd4,  2'd1, 4'd3, 32'h0000_8000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_8000},
    '{8'd7,  2'd2, 4'd3, 32'h0000_8000, 12'h000, 64'h3,    1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_8000}, // R7 same-cycle store
    '{8'd7,  2'd1, 4'd3, 32'h0000_9000, 12'h000, 64'h0,    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_9000}, // R7 same-cycle load
    '{8'd7,  2'd2, 4'd3, 32'h0000_9000, 12'h000, 64'hC0DE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_9000}, // R7
    '{8'd9,  2'd1, 4'd3, 32'h0000_A000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_A000},
    '{8'd9,  2'd1, 4'd3, 32'h0000_B000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_B000}, // R9 replace
    '{8'd9,  2'd2, 4'd3, 32'h0000_A000, 12'h000, 64'h4,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_A000}, // R9 old fails
    '{8'd9,  2'd1, 4'd3, 32'h0000_B000, 12'h000, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_B000},
    '{8'd9,  2'd2, 4'd3, 32'h0000_B000, 12'h000, 64'hF00D, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_B000}, // R9
    '{8'd2,  2'd1, 4'd3, 32'hFFFF_FFF8, 12'h010, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0008}, // R2 wrap
    '{8'd2,  2'd2, 4'd3, 32'h0000_0000, 12'h008, 64'h6,    1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0008}, // R2
    '{8'd6,  2'd2, 4'd3, 32'h0000_0000, 12'h008, 64'h6,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0008}  // R6
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    op_i = '0;
  logic [3:0]    func_i = '0;
  logic [AW-1:0] base_i = '0;
  logic [11:0]   disp_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          clr_i = 1'b0;
  logic          mem_rd_o, mem_we_o, mem_quad_o, sc_done_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, sc_result_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  llsc_monitor #(.AW(AW), .DW(DW)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op_i),
    .func_i      (func_i),
    .base_i      (base_i),
    .disp_i      (disp_i),
    .data_i      (data_i),
    .clr_i       (clr_i),
    .mem_rd_o    (mem_rd_o),
    .mem_we_o    (mem_we_o),
    .mem_quad_o  (mem_quad_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .sc_done_o   (sc_done_o),
    .sc_result_o (sc_result_o)
  );

  task automatic check(input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [3:0] fn,
                       input logic [31:0] base, input logic [11:0] disp,
                       input logic [63:0] data, input logic clr);
    op_i = op; func_i = fn; base_i = base; disp_i = disp; data_i = data; clr_i = clr;
  endtask

  task automatic quiet(input int req, input string tag);
    check(req, {tag, " rd"},   64'(mem_rd_o),  64'd0);
    check(req, {tag, " we"},   64'(mem_we_o),  64'd0);
    check(req, {tag, " done"}, 64'(sc_done_o), 64'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 5000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs quiet in reset, with a store request pending
    drive(2'd2, 4'd3, 32'h100, 12'h0, 64'h1, 1'b0);
    repeat (2) @(negedge clk_i);
    quiet(1, "in reset");
    rst_ni = 1'b1;
    drive(2'd0, 4'd0, 32'h0, 12'h0, 64'h0, 1'b0);
    @(negedge clk_i);
    quiet(1, "after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].fn, VECS[i].base, VECS[i].disp, VECS[i].data, VECS[i].clr);
      @(negedge clk_i);
      check(VECS[i].req, $sformatf("v%0d rd", i),   64'(mem_rd_o),  64'(VECS[i].rd));
      check(VECS[i].req, $sformatf("v%0d we", i),   64'(mem_we_o),  64'(VECS[i].we));
      check(VECS[i].req, $sformatf("v%0d done", i), 64'(sc_done_o), 64'(VECS[i].done));
      if (VECS[i].done)
        check(VECS[i].req, $sformatf("v%0d result", i), sc_result_o, 64'(VECS[i].res));
      if (VECS[i].rd || VECS[i].we) begin
        check(VECS[i].req, $sformatf("v%0d addr", i), 64'(mem_addr_o), 64'(VECS[i].addr));
        check(3, $sformatf("v%0d quad", i), 64'(mem_quad_o), 64'(VECS[i].fn == 4'd3));
      end
      if (VECS[i].we)
        check(4, $sformatf("v%0d wdata", i), mem_wdata_o, VECS[i].data);
    end

    // R1: reset drops a held reservation
    drive(2'd1, 4'd3, 32'h0000_C000, 12'h0, 64'h0, 1'b0);
    @(negedge clk_i);
    check(1, "pre-reset load rd", 64'(mem_rd_o), 64'd1);
    drive(2'd0, 4'd0, 32'h0, 12'h0, 64'h0, 1'b0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    quiet(1, "mid reset");
    rst_ni = 1'b1;
    drive(2'd2, 4'd3, 32'h0000_C000, 12'h0, 64'h5, 1'b0);
    @(negedge clk_i);
    check(1, "store after reset done", 64'(sc_done_o), 64'd1);
    check(1, "store after reset result", sc_result_o, 64'd0);
    check(1, "store after reset we", 64'(mem_we_o), 64'd0);

    drive(2'd0, 4'd0, 32'h0, 12'h0, 64'h0, 1'b0);
    @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule